// File: doc/BRIEF.md
# Selectable Reset-Pulse Source with Service Watchdog

This block drives a single reset-output pin from one source chosen by a 2-bit select field. The field can leave the pin silent, pass on a rising edge of a command-code-change strobe, pass on a rising edge of an external wake strobe, or hand the pin to an internal watchdog. Every source produces the same fixed-width reset pulse. The pulse length is a parameter in clock cycles. A trigger that arrives while a pulse is already being driven is dropped.

Choosing the watchdog locks the select field until the next hardware reset. The counter starts from zero at the write that chooses it. Software keeps the watchdog quiet by writing the 2-bit service field in a fixed two-step pattern: first 10, then 01 on the next write. This must happen within every timeout period, which is also a parameter in clock cycles. If the period runs out, the block emits one pulse. The counter then restarts from zero once the pulse ends.

The processor reaches the block through one write strobe that carries both fields. Address decoding sits outside the block. The hardware reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `reset_source_sel`

## Requirements
- R1: While `rst_n` is low and after its release, `rst_out` is low, the select field reads 00 (no source), the watchdog is off and the select field can be written again.
- R2: With select 00, no edge on either event input and no write of the service field ever raises `rst_out`.
- R3: With select 01, a rising edge of `cmd_chg_evt` sampled at a clock edge raises `rst_out` at that same edge; edges of `wake_evt` are ignored.
- R4: With select 10, a rising edge of `wake_evt` sampled at a clock edge raises `rst_out` at that same edge; edges of `cmd_chg_evt` are ignored.
- R5: Every pulse on `rst_out` lasts exactly PULSE_CYC cycles, and triggers that occur while a pulse is active are dropped.
- R6: A write with select 11 turns the watchdog on and clears its counter; without service, `rst_out` rises WDOG_CYC clock edges after the edge that took that write.
- R7: A write whose service field is 10, followed by the next write with service field 01, clears the counter at the second write; the next expiry pulse rises WDOG_CYC edges after it.
- R8: Any other write breaks the service sequence without clearing the counter. This includes a second 10, a lone 01, and a service field of 00 or 11.
- R9: After an expiry pulse, the counter stays at zero until the pulse ends and then runs again, so unserviced pulses rise every WDOG_CYC + PULSE_CYC cycles.
- R10: Once the watchdog is on, writes to the select field have no effect: event inputs stay ignored and the watchdog keeps running until `rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Source select written with the strobe (00 none, 01 command change, 10 wake, 11 watchdog) |
| wr_svc | input | 2 | Watchdog service field written with the strobe (step one 10, step two 01) |
| cmd_chg_evt | input | 1 | Command-code-change event, acts on its rising edge |
| wake_evt | input | 1 | External wake event, acts on its rising edge |
| rst_out | output | 1 | Reset-output pulse, active high |

## Verification
A service tracker left armed or wrongly cleared shows up at the port as an expiry pulse that rises at the wrong edge. That difference is visible within one timeout period after the last service write. A select field that is not locked shows up as soon as an event edge arrives after a rewrite, because that edge then produces a pulse that should not exist. A counter that fails to hold at zero during a pulse moves every following expiry earlier by PULSE_CYC cycles, which shows at the next rising edge of the pin. The scoreboard predicts each pulse by its start cycle and width from the stimulus alone, and it treats any pulse it did not predict as an error.

// File: rtl/rstsel_pkg.sv
package rstsel_pkg;

  // Source select codes; the code decides which trigger reaches the pin.
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_CMD  = 2'b01,
    SRC_WAKE = 2'b10,
    SRC_WDOG = 2'b11
  } src_sel_e;

  // Two-step service pattern, in the order it must be written.
  localparam logic [1:0] SVC_STEP1 = 2'b10;
  localparam logic [1:0] SVC_STEP2 = 2'b01;

  typedef enum logic {
    TRK_IDLE  = 1'b0,
    TRK_ARMED = 1'b1
  } svc_trk_e;

endpackage

// File: rtl/rstsel_rsync.sv
module rstsel_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rstsel_cfg.sv
module rstsel_cfg
  import rstsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [1:0] wr_svc,
  output src_sel_e   sel_q,
  output logic       wd_en_q,
  output logic       wd_start,
  output logic       svc_ok
);

  src_sel_e sel_d;
  logic     wd_en_d;
  logic     cfg_ce;
  svc_trk_e trk_q;
  svc_trk_e trk_d;

  // Select register: writable only until the watchdog has been chosen.
  always_comb begin
    sel_d    = sel_q;
    wd_en_d  = wd_en_q;
    wd_start = 1'b0;
    cfg_ce   = wr_en && !wd_en_q;
    if (cfg_ce) begin
      sel_d = src_sel_e'(wr_sel);
      if (wr_sel == SRC_WDOG) begin
        wd_en_d  = 1'b1;
        wd_start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SRC_NONE;
      wd_en_q <= 1'b0;
    end else if (cfg_ce) begin
      sel_q   <= sel_d;
      wd_en_q <= wd_en_d;
    end
  end

  // Service tracker: step one arms, step two on the very next write completes;
  // every other write returns to idle.
  always_comb begin
    trk_d  = trk_q;
    svc_ok = 1'b0;
    if (wr_en) begin
      if (trk_q == TRK_ARMED && wr_svc == SVC_STEP2) begin
        svc_ok = 1'b1;
        trk_d  = TRK_IDLE;
      end else if (trk_q == TRK_IDLE && wr_svc == SVC_STEP1) begin
        trk_d  = TRK_ARMED;
      end else begin
        trk_d  = TRK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q <= TRK_IDLE;
    end else if (wr_en) begin
      trk_q <= trk_d;
    end
  end

endmodule

// File: rtl/rstsel_wdog.sv
module rstsel_wdog #(
  parameter int WDOG_CYC = 983040,
  localparam int CNT_W   = $clog2(WDOG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_en,
  input  logic             wd_start,
  input  logic             svc_ok,
  input  logic             hold,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WDOG_CYC - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             at_last;

  always_comb begin
    cnt_ce  = wd_en || wd_start;
    at_last = (cnt_q == CNT_LAST);
    expire  = 1'b0;
    cnt_d   = cnt_q;
    if (!wd_en || wd_start) begin
      cnt_d = '0;
    end else if (hold || svc_ok) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d  = '0;
      expire = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rstsel_pulse.sv
module rstsel_pulse
  import rstsel_pkg::*;
#(
  parameter int PULSE_CYC = 1440,
  localparam int PW       = $clog2(PULSE_CYC + 1),
  localparam int N_EVT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_sel_e         sel_q,
  input  logic             wd_expire,
  input  logic [N_EVT-1:0] evt_in,
  output logic             busy_q
);

  localparam logic [PW-1:0] PCNT_LOAD = PW'(PULSE_CYC - 1);

  logic [N_EVT-1:0] evt_prev_q;
  logic [N_EVT-1:0] evt_hit;
  logic             trig;
  logic             busy_d;
  logic [PW-1:0]    pcnt_q;
  logic [PW-1:0]    pcnt_d;

  // One edge detector per event input, each routed by its own select code.
  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    localparam src_sel_e MY_SRC = (i == 0) ? SRC_CMD : SRC_WAKE;
    assign evt_hit[i] = evt_in[i] && !evt_prev_q[i] && (sel_q == MY_SRC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev_q <= '0;
    end else begin
      evt_prev_q <= evt_in;
    end
  end

  always_comb begin
    trig   = wd_expire || (|evt_hit);
    busy_d = busy_q;
    pcnt_d = pcnt_q;
    if (!busy_q) begin
      if (trig) begin
        busy_d = 1'b1;
        pcnt_d = PCNT_LOAD;
      end
    end else if (pcnt_q == '0) begin
      busy_d = 1'b0;
    end else begin
      pcnt_d = pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/reset_source_sel.sv
module reset_source_sel
  import rstsel_pkg::*;
#(
  parameter int WDOG_CYC    = 983040,
  parameter int PULSE_CYC   = 1440,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WDOG_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [1:0] wr_svc,
  input  logic       cmd_chg_evt,
  input  logic       wake_evt,
  output logic       rst_out
);

  logic             rst_sync_n;
  src_sel_e         sel_q;
  logic             wd_en;
  logic             wd_start;
  logic             svc_ok;
  logic             wd_expire;
  logic [CNT_W-1:0] wd_cnt;
  logic             busy;

  rstsel_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rstsel_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_svc   (wr_svc),
    .sel_q    (sel_q),
    .wd_en_q  (wd_en),
    .wd_start (wd_start),
    .svc_ok   (svc_ok)
  );

  rstsel_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wd_en    (wd_en),
    .wd_start (wd_start),
    .svc_ok   (svc_ok),
    .hold     (busy),
    .expire   (wd_expire),
    .cnt_q    (wd_cnt)
  );

  rstsel_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_q     (sel_q),
    .wd_expire (wd_expire),
    .evt_in    ({wake_evt, cmd_chg_evt}),
    .busy_q    (busy)
  );

  assign rst_out = busy;

endmodule

// File: rtl/reset_source_sel_chk.sv
module reset_source_sel_chk
  import rstsel_pkg::*;
#(
  parameter int WDOG_CYC  = 983040,
  parameter int PULSE_CYC = 1440,
  localparam int CNT_W    = $clog2(WDOG_CYC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_out,
  input logic [1:0]       sel_q,
  input logic             wd_en,
  input logic [CNT_W-1:0] wd_cnt
);

  int unsigned hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= 0;
    end else if (rst_out) begin
      hi_len <= hi_len + 1;
    end else begin
      hi_len <= 0;
    end
  end

  // R1
  always_comb begin
    reset_low_chk: assert (rst_n || !rst_out);
  end

  // R2
  rise_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(sel_q) != SRC_NONE);

  // R5
  pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> hi_len < PULSE_CYC);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> hi_len == PULSE_CYC);

  // R6
  wd_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_en) |-> wd_cnt == '0);

  // R6
  wd_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt < CNT_W'(WDOG_CYC));

  // R9
  wd_hold_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && $fell(rst_out)) |-> wd_cnt == '0);

  // R10
  wd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);

  // R10
  wd_sel_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |-> sel_q == SRC_WDOG);

endmodule

bind reset_source_sel reset_source_sel_chk #(
  .WDOG_CYC  (WDOG_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_out (rst_out),
  .sel_q   (sel_q),
  .wd_en   (wd_en),
  .wd_cnt  (wd_cnt)
);

// File: tb/reset_source_sel_tb.sv
module reset_source_sel_tb;

  localparam time CLK_PERIOD = 10;
  localparam int  P          = 200;
  localparam int  W          = 8;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [1:0] wr_svc;
  logic       cmd_chg_evt;
  logic       wake_evt;
  logic       rst_out;

  typedef struct {
    int    start;
    string req;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   done   = 1'b0;

  reset_source_sel #(.WDOG_CYC(P), .PULSE_CYC(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_svc      (wr_svc),
    .cmd_chg_evt (cmd_chg_evt),
    .wake_evt    (wake_evt),
    .rst_out     (rst_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected pulse per rising edge of rst_out.
  logic mon_prev = 1'b0;
  int   mon_len  = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_out && !mon_prev) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2", "unpredicted pulse at cycle", cyc, -1);
        cur.req   = "R2";
        cur.start = cyc;
      end else begin
        cur = sb_q.pop_front();
        chk(cyc == cur.start, cur.req, "pulse start cycle", cyc, cur.start);
      end
      mon_len = 1;
    end else if (rst_out) begin
      mon_len++;
    end else if (mon_prev) begin
      chk(mon_len == W, "R5", {"pulse width for ", cur.req}, mon_len, W);
    end
    mon_prev = rst_out;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Driver: one write; returns the clock edge that takes it.
  task automatic do_write(input logic [1:0] s, input logic [1:0] v, output int cap);
    cap    = cyc + 1;
    wr_en  = 1'b1;
    wr_sel = s;
    wr_svc = v;
    @(negedge clk);
    wr_en  = 1'b0;
    wr_sel = 2'b00;
    wr_svc = 2'b00;
  endtask

  // Driver: one event strobe; pushes a prediction when a pulse is due.
  task automatic do_evt(input bit wake, input bit expect_pulse, input string req);
    exp_t e;
    if (expect_pulse) begin
      e.start = cyc + 1;
      e.req   = req;
      sb_q.push_back(e);
    end
    if (wake) wake_evt = 1'b1;
    else      cmd_chg_evt = 1'b1;
    @(negedge clk);
    wake_evt    = 1'b0;
    cmd_chg_evt = 1'b0;
  endtask

  task automatic predict(input int start, input string req);
    exp_t e;
    e.start = start;
    e.req   = req;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R1", "bench watchdog expired at cycle", cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    int c;
    int m;
    int r;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'b00; wr_svc = 2'b00;
    cmd_chg_evt = 1'b0; wake_evt = 1'b0;
    idle(3);
    chk(rst_out == 1'b0, "R1", "rst_out during reset", rst_out, 0);
    rst_n = 1'b1;
    idle(4);
    chk(rst_out == 1'b0, "R1", "rst_out after reset", rst_out, 0);

    // R2: nothing selected, events and service writes do nothing
    do_evt(1'b0, 1'b0, "R2");
    idle(3);
    do_evt(1'b1, 1'b0, "R2");
    do_write(2'b00, 2'b10, c);
    do_write(2'b00, 2'b01, c);
    idle(20);
    chk(rst_out == 1'b0, "R2", "rst_out with no source", rst_out, 0);

    // R3: command-change source
    do_write(2'b01, 2'b00, c);
    idle(2);
    do_evt(1'b0, 1'b1, "R3");
    idle(3);
    do_evt(1'b0, 1'b0, "R5");   // second trigger during the pulse is dropped
    idle(20);
    do_evt(1'b1, 1'b0, "R3");   // wake ignored with select 01
    idle(20);
    chk(sb_q.size() == 0, "R3", "pending predictions", sb_q.size(), 0);

    // R4: wake source
    do_write(2'b10, 2'b00, c);
    idle(2);
    do_evt(1'b1, 1'b1, "R4");
    idle(20);
    do_evt(1'b0, 1'b0, "R4");   // command change ignored with select 10
    idle(20);
    chk(sb_q.size() == 0, "R4", "pending predictions", sb_q.size(), 0);

    // R6: watchdog enable and unserviced expiry
    do_write(2'b11, 2'b00, c);
    predict(c + P, "R6");
    wait_until(c + P - 2);
    chk(rst_out == 1'b0, "R6", "rst_out just before expiry", rst_out, 0);
    wait_until(c + P + W + 2);

    // R7: valid service sequence
    idle(30);
    do_write(2'b11, 2'b10, m);
    do_write(2'b11, 2'b01, m);
    predict(m + P, "R7");

    // R8: broken sequences must not service
    idle(20);
    do_write(2'b11, 2'b01, c);
    idle(5);
    do_write(2'b11, 2'b10, c);
    do_write(2'b11, 2'b10, c);
    do_write(2'b11, 2'b01, c);
    idle(5);
    do_write(2'b11, 2'b10, c);
    do_write(2'b11, 2'b00, c);
    do_write(2'b11, 2'b01, c);
    idle(5);
    do_write(2'b11, 2'b10, c);
    do_write(2'b11, 2'b11, c);
    do_write(2'b11, 2'b01, c);
    wait_until(m + P - 1);
    chk(rst_out == 1'b0, "R8", "rst_out one edge before serviced expiry", rst_out, 0);
    wait_until(m + P + 1);
    chk(rst_out == 1'b1, "R8", "rst_out after serviced expiry", rst_out, 1);

    // R9: free-running repeat after the pulse
    r = m + P;
    predict(r + W + P, "R9");

    // R10: select writes ignored while the watchdog is on
    wait_until(r + W + 5);
    do_write(2'b00, 2'b00, c);
    do_write(2'b01, 2'b00, c);
    idle(2);
    do_evt(1'b0, 1'b0, "R10");
    do_evt(1'b1, 1'b0, "R10");
    wait_until(r + W + P + W + 3);
    chk(sb_q.size() == 0, "R9", "pending predictions", sb_q.size(), 0);

    // R1: hardware reset turns the watchdog off and frees the select field
    rst_n = 1'b0;
    idle(1);
    chk(rst_out == 1'b0, "R1", "rst_out in second reset", rst_out, 0);
    rst_n = 1'b1;
    idle(4);
    idle(P + 50);
    chk(rst_out == 1'b0, "R1", "rst_out after watchdog cleared", rst_out, 0);
    do_evt(1'b0, 1'b0, "R1");
    idle(5);
    do_write(2'b01, 2'b00, c);
    idle(2);
    do_evt(1'b0, 1'b1, "R1");
    idle(W + 5);
    chk(sb_q.size() == 0, "R1", "pending predictions at end", sb_q.size(), 0);
    finish_run();
  end

endmodule